// File: doc/BRIEF.md
# Byte Check-Bit Encoder with Write-Wrap Flag

This block derives four even-parity check bits from an 8-bit data byte. The bits belong to a single-error-locating byte code, and each one covers its own fixed, unequal subset of the data bits. The check bits are pure combinational logic. A consumer can latch them together with the byte at the moment it stores the byte.

Beside the encoder, a 4-bit counter is clocked by the trailing (rising) edge of an active-low write strobe. On each strobe edge, a flag register records whether the counter stood at its top value, 15, before that edge. The flag is therefore high from the sixteenth write until the next write. A register clocked on the falling edge of a system clock retimes the flag into the system domain. The result is a block-complete output. One active-low asynchronous clear resets the counter, the flag and the output register.

Top module: `byte_chk_wrap`

## Requirements
- R1: `chk[0]` equals the XOR of data bits 0, 2, 4, 5 and 6.
- R2: `chk[1]` equals the XOR of data bits 1, 3, 4, 5 and 7.
- R3: `chk[2]` equals the XOR of data bits 0, 1, 4, 6 and 7.
- R4: `chk[3]` equals the XOR of data bits 2, 3, 5, 6 and 7.
- R5: `chk` depends on `data` alone and follows a change in `data` with no clock or strobe edge.
- R6: Each rising edge of `wr_n` advances an internal 4-bit write count by one, and the count wraps from 15 to 0.
- R7: The internal flag is high after exactly those strobe edges that wrap the count. These are writes 16, 32, 48 and so on after a clear. It returns low on the next write.
- R8: `done` takes the value of the internal flag at each falling edge of `clk`.
- R9: While `clr_n` is low, `done` is 0 at once, without any clock edge. After release, the next flag needs sixteen new writes.
- R10: Flipping any single data bit toggles at least two check bits. The resulting 4-bit pattern of changed check bits is different for each of the eight data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; `done` is updated on its falling edge |
| clr_n | input | 1 | Active-low asynchronous clear of all registers |
| wr_n | input | 1 | Active-low write strobe; its rising edge counts one write |
| data | input | 8 | Data byte to encode |
| chk | output | 4 | Even-parity check bits, combinational from `data` |
| done | output | 1 | Wrap flag retimed into the `clk` domain |

## Verification
The assertions assume that `wr_n` and `clk` are independent clocks and that the flag never changes close to a falling edge of `clk`. The stimulus therefore moves `wr_n` high only a quarter period after a rising edge of `clk`, well away from the falling edges. The assertions also assume that `clr_n` is released away from both active edges. The stimulus releases it at the same mid-cycle point, so recovery to either clock is never at stake. `data` is held stable across each strobe edge, and the encoder is checked both through strobe activity and through changes of `data` alone.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int CNT_W  = 4;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    // Coverage of each check bit over the data byte (bit i set: data bit i covered)
    localparam logic [DATA_W-1:0] COVER_MASK [CHK_W] = '{
        8'h75,  // check 0: data 6,5,4,2,0
        8'hBA,  // check 1: data 7,5,4,3,1
        8'hD3,  // check 2: data 7,6,4,1,0
        8'hEC   // check 3: data 7,6,5,3,2
    };

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } wr_state_t;
endpackage

// File: rtl/bcw_encoder.sv
module bcw_encoder
    import bcw_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    // One reduction-XOR tree per check bit (R1..R4), no register (R5)
    for (genvar g = 0; g < CHK_W; g++) begin : g_chk
        logic [DATA_W-1:0] picked;
        always_comb begin
            picked   = data_i & COVER_MASK[g];
            chk_o[g] = ^picked;
        end
    end
endmodule

// File: rtl/bcw_wr_counter.sv
module bcw_wr_counter
    import bcw_pkg::*;
(
    input  logic wr_n,
    input  logic clr_n,
    output logic flag_o
);
    wr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + 1'b1;          // wraps naturally
        st_d.flag = (st_q.cnt == CNT_TOP);    // wrap write raises the flag
    end

    always_ff @(posedge wr_n or negedge clr_n) begin
        if (!clr_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    assert_wrap_to_zero_R6: assert property (@(posedge wr_n) disable iff (!clr_n)
        (st_q.cnt == CNT_TOP) |=> (st_q.cnt == '0));
    assert_flag_on_wrap_R7: assert property (@(posedge wr_n) disable iff (!clr_n)
        (st_q.cnt == CNT_TOP) |=> st_q.flag);
    assert_flag_one_write_R7: assert property (@(posedge wr_n) disable iff (!clr_n)
        st_q.flag |=> !st_q.flag);
    assert_flag_count_zero_R7: assert property (@(posedge wr_n) disable iff (!clr_n)
        st_q.flag |-> (st_q.cnt == '0));
endmodule

// File: rtl/bcw_resync.sv
module bcw_resync (
    input  logic clk,
    input  logic clr_n,
    input  logic flag_i,
    output logic done_o
);
    logic done_d, done_q;

    always_comb done_d = flag_i;

    always_ff @(negedge clk or negedge clr_n) begin
        if (!clr_n) done_q <= 1'b0;
        else        done_q <= done_d;
    end

    assign done_o = done_q;

    assert_done_follows_R8: assert property (@(negedge clk) disable iff (!clr_n)
        done_q == $past(flag_i));
endmodule

// File: rtl/byte_chk_wrap.sv
module byte_chk_wrap
    import bcw_pkg::*;
(
    input  logic              clk,
    input  logic              clr_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk,
    output logic              done
);
    logic flag;

    bcw_encoder u_enc (
        .data_i (data),
        .chk_o  (chk)
    );

    bcw_wr_counter u_cnt (
        .wr_n   (wr_n),
        .clr_n  (clr_n),
        .flag_o (flag)
    );

    bcw_resync u_sync (
        .clk    (clk),
        .clr_n  (clr_n),
        .flag_i (flag),
        .done_o (done)
    );
endmodule

// File: tb/sim_byte_chk_wrap.sv
`timescale 1ns/1ps
module sim_byte_chk_wrap;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       wr_n = 1'b1;
    logic [7:0] data = 8'h00;
    logic [3:0] chk;
    logic       done;

    int  n_run = 0, n_fail = 0;
    int  writes = 0;
    bit  flag_m = 0, exp_done = 0, mon_on = 0, finished = 0;

    byte_chk_wrap u0 (.clk(clk), .clr_n(clr_n), .wr_n(wr_n), .data(data), .chk(chk), .done(done));

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [3:0] ref_chk(input logic [7:0] d);
        logic [3:0] c;
        c[0] = d[0] ^ d[2] ^ d[4] ^ d[5] ^ d[6];
        c[1] = d[1] ^ d[3] ^ d[4] ^ d[5] ^ d[7];
        c[2] = d[0] ^ d[1] ^ d[4] ^ d[6] ^ d[7];
        c[3] = d[2] ^ d[3] ^ d[5] ^ d[6] ^ d[7];
        return c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model of the retiming register
    always @(negedge clk or negedge clr_n)
        if (!clr_n) exp_done <= 1'b0;
        else        exp_done <= flag_m;

    // compare on every clock, away from the falling edge
    always @(posedge clk) if (mon_on) begin
        check("R8 done per clock", done, exp_done);
        check("R1 R2 R3 R4 chk per clock", chk, ref_chk(data));
    end

    task automatic do_write(input logic [7:0] d);
        @(posedge clk); #1;
        data = d;
        wr_n = 1'b0;
        @(posedge clk); #2;
        wr_n = 1'b1;                 // count edge, mid-cycle
        writes++;
        flag_m = (writes % 16 == 0);
    endtask

    task automatic do_clear();
        @(posedge clk); #2;
        clr_n = 1'b0;
        flag_m = 0; writes = 0;
        #1;
        check("R9 done cleared async", done, 0);
        @(posedge clk); #2;
        clr_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        check("R9 reset done", done, 0);
        repeat (2) @(posedge clk);
        #2 clr_n = 1'b1;
        mon_on = 1;

        // R5: combinational, no strobe or clock needed
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); #1;
            data = 8'(i * 37 + 5);
            #1;
            check("R5 chk follows data", chk, ref_chk(data));
        end

        // R1..R4 exhaustive over all bytes
        for (int v = 0; v < 256; v++) begin
            data = 8'(v); #1;
            check("R1 chk0", chk[0], ^(data & 8'h75));
            check("R2 chk1", chk[1], ^(data & 8'hBA));
            check("R3 chk2", chk[2], ^(data & 8'hD3));
            check("R4 chk3", chk[3], ^(data & 8'hEC));
        end

        // R10: single-bit syndromes
        begin
            logic [3:0] syn [8];
            data = 8'h00; #1;
            for (int b = 0; b < 8; b++) begin
                logic [3:0] base;
                base = chk;
                data = 8'(1 << b); #1;
                syn[b] = chk ^ base;
                check("R10 weight >= 2", ($countones(syn[b]) >= 2), 1);
                data = 8'h00; #1;
            end
            for (int a = 0; a < 8; a++)
                for (int b = a + 1; b < 8; b++)
                    check("R10 distinct syndromes", (syn[a] != syn[b]), 1);
        end

        // R6 R7 R8: done only after every sixteenth write
        for (int w = 1; w <= 40; w++) begin
            do_write(8'($urandom));
            @(negedge clk); #1;
            check("R7 done after write", done, (w % 16 == 0));
            check("R1 R2 R3 R4 chk on write", chk, ref_chk(data));
        end

        // R9: clear mid-count, then sixteen fresh writes needed
        do_clear();
        for (int w = 1; w <= 16; w++) begin
            do_write(8'($urandom));
            @(negedge clk); #1;
            check("R9 restart count", done, (w == 16));
        end
        // R6 wrap again: one more write drops the flag
        do_write(8'hA5);
        @(negedge clk); #1;
        check("R6 flag drops after wrap", done, 0);

        // R9 clear while done is high
        for (int w = 0; w < 15; w++) do_write(8'(w));
        @(negedge clk); #1;
        check("R7 done high at 32nd", done, 1);
        do_clear();
        @(negedge clk); #1;
        check("R9 done stays low", done, 0);

        mon_on = 0;
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule